// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-visible register front end of one DMA channel. It holds four 32-bit words: a control/status word, a transfer address that counts forward, and two plain scratch words. They are reached by single-cycle 32-bit accesses on a simple valid/write strobe bus, and reads have no wait states.

The status word carries several kinds of bits:

- a hardwired version field;
- a read-only pending-interrupt bit, which follows the edges of a level interrupt from the attached peripheral;
- a sticky flag that records that the address was programmed;
- two command bits that never read back. One pulses a reset line to the peripheral. The other requests a FIFO drain.
- an interrupt enable, which gates the pending bit onto the interrupt output;
- a DMA enable bit, which drives the enable line of the data mover.

The data mover reports each completed transfer with a strobe and a byte count. The address word then advances by that count.

Top module: `dma_csr_block`

## Requirements
- R1: Register index is bus_addr[3:2]: 0 status, 1 address, 2 and 3 scratch. Address bits above bit 3 and below bit 2 are ignored. A read (bus_valid=1, bus_write=0) returns the indexed word on bus_rdata in the same cycle.
- R2: After reset, the status word reads 0xA0000000, the other three words read 0, and irq_out, periph_reset_out and dma_en_out are 0.
- R3: Status bits under mask 0xFE000007 are not changed by writes. Bits 31 and 29 always read 1. Bits 30, 28, 27, 25, 2 and 1 always read 0.
- R4: Status bit 0 (pending) sets one clock after periph_irq is sampled rising and clears one clock after it is sampled falling. irq_out equals status bit 4 (interrupt enable) AND the pending bit, registered.
- R5: A status write that sets bit 4 while pending is set raises irq_out on the next clock. A status write that clears bit 4 drops irq_out on the next clock.
- R6: A status write with bit 7 set drives periph_reset_out high for exactly the next clock. Bit 7 always reads 0.
- R7: Status bit 6 (drain request) always reads 0, even directly after a write that sets it.
- R8: dma_en_out equals status bit 9. It rises after a write that takes bit 9 from 0 to 1 and falls after a write that takes it from 1 to 0.
- R9: Any write to index 1 sets status bit 26 (loaded). The bit then stays set until reset.
- R10: When xfer_valid is high, the address word advances by the zero-extended xfer_len, modulo 2^32.
- R11: If an address write and xfer_valid fall in the same cycle, the written value is stored and no advance is applied.
- R12: If a status write and an interrupt edge fall in the same cycle, both take effect: irq_out becomes the new enable AND the new pending.
- R13: bus_rdata is 0 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| periph_irq | input | 1 | Level interrupt from the peripheral |
| xfer_valid | input | 1 | One transfer completed this cycle |
| xfer_len | input | LEN_W | Bytes moved by that transfer |
| irq_out | output | 1 | Gated interrupt to the host |
| periph_reset_out | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_out | output | 1 | DMA enable to the data mover |

## Verification
Two pairs of functions can meet in one cycle.

- A software write to the address word can coincide with a transfer-completion strobe. The written value must win and the advance must be dropped.
- A status write that changes the interrupt enable can coincide with a sampled edge of periph_irq. irq_out must reflect both the new enable and the new pending state.

Directed cycles force each collision on purpose. The random phase drives the bus, the interrupt line and the transfer strobe independently, so both collisions also occur often there. Every cycle is judged against a bench model that applies the write first and the edge or advance rule second.

// File: rtl/dma_csr_pkg.sv
// Package: shared constants for the DMA channel register block.
// Assumes 32-bit registers and a four-word register window.
package dma_csr_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int IDX_LSB  = 2;

    localparam logic [REG_W-1:0] VERSION_WORD = 32'hA000_0000;
    localparam logic [REG_W-1:0] RO_MASK      = 32'hFE00_0007;

    localparam int BIT_PEND   = 0;
    localparam int BIT_IEN    = 4;
    localparam int BIT_DRAIN  = 6;
    localparam int BIT_RESET  = 7;
    localparam int BIT_DMAEN  = 9;
    localparam int BIT_LOADED = 26;

    // Writable bits that are actually held in flops (command bits excluded)
    localparam logic [REG_W-1:0] STORE_MASK =
        ~RO_MASK & ~(32'h1 << BIT_DRAIN) & ~(32'h1 << BIT_RESET);

    typedef enum logic [IDX_W-1:0] {
        IDX_CSR  = 2'd0,
        IDX_ADDR = 2'd1,
        IDX_AUX0 = 2'd2,
        IDX_AUX1 = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/dma_irq_gate.sv
// Module: tracks a level interrupt input through a pending bit and gates
// it with the interrupt enable. Assumes irq_in is already synchronous.
// ien_next is the enable value that will hold after this clock.
module dma_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic ien_next,
    output logic pending,
    output logic irq_out
);
    logic irq_prev_q;
    logic pend_next;

    // Pending follows sampled edges of the input
    always_comb begin
        pend_next = pending;
        if (irq_in && !irq_prev_q)
            pend_next = 1'b1;
        else if (!irq_in && irq_prev_q && pending)
            pend_next = 1'b0;
    end

    // Edge history, pending bit and gated output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prev_q <= 1'b0;
            pending    <= 1'b0;
            irq_out    <= 1'b0;
        end else begin
            irq_prev_q <= irq_in;
            pending    <= pend_next;
            irq_out    <= ien_next & pend_next;
        end
    end
endmodule

// File: rtl/dma_addr_counter.sv
// Module: transfer address register with software load and hardware
// advance. A load has priority over an advance in the same cycle.
// Also keeps the sticky "address loaded" flag.
module dma_addr_counter #(
    parameter int REG_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             adv,
    input  logic [LEN_W-1:0] adv_len,
    output logic [REG_W-1:0] addr,
    output logic             loaded
);
    localparam int PAD_W = REG_W - LEN_W;

    logic [REG_W-1:0] step;

    // Zero-extend the byte count to register width
    assign step = {{PAD_W{1'b0}}, adv_len};

    // Address update: load wins, otherwise advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            loaded <= 1'b0;
        end else if (load) begin
            addr   <= load_val;
            loaded <= 1'b1;
        end else if (adv) begin
            addr   <= addr + step;
        end
    end
endmodule

// File: rtl/dma_csr_block.sv
// Module: register block of one DMA channel. Decodes word accesses,
// holds the status word and scratch words, and drives the peripheral
// reset pulse, the DMA enable and the gated interrupt.
// Assumes ADDR_W > 4 and single-cycle accesses without back-pressure.
module dma_csr_block
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              periph_irq,
    input  logic              xfer_valid,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              irq_out,
    output logic              periph_reset_out,
    output logic              dma_en_out
);
    localparam int NUM_AUX = NUM_REGS - 2;

    logic [IDX_W-1:0] idx;
    logic             wr, rd, wr_csr, wr_addr;
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] csr_word;
    logic [REG_W-1:0] addr_word;
    logic [REG_W-1:0] aux_q [NUM_AUX];
    logic             pending, loaded, ien_next, rst_pulse_q;
    logic             unused_addr;

    // Access decode
    assign idx         = bus_addr[IDX_LSB +: IDX_W];
    assign unused_addr = ^{bus_addr[ADDR_W-1:IDX_LSB+IDX_W], bus_addr[IDX_LSB-1:0]};
    assign wr          = bus_valid & bus_write;
    assign rd          = bus_valid & ~bus_write;
    assign wr_csr      = wr && (idx == IDX_CSR);
    assign wr_addr     = wr && (idx == IDX_ADDR);

    // Stored writable part of the status word
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_csr)
            ctrl_q <= bus_wdata & STORE_MASK;
    end

    // One-cycle peripheral reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_pulse_q <= 1'b0;
        else
            rst_pulse_q <= wr_csr & bus_wdata[BIT_RESET];
    end

    // Enable value after this clock, seen by the interrupt gate
    assign ien_next = wr_csr ? bus_wdata[BIT_IEN] : ctrl_q[BIT_IEN];

    dma_irq_gate u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (periph_irq),
        .ien_next (ien_next),
        .pending  (pending),
        .irq_out  (irq_out)
    );

    dma_addr_counter #(.REG_W(REG_W), .LEN_W(LEN_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_addr),
        .load_val (bus_wdata),
        .adv      (xfer_valid),
        .adv_len  (xfer_len),
        .addr     (addr_word),
        .loaded   (loaded)
    );

    // Scratch words, one flop bank per index
    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        always_ff @(posedge clk) begin
            if (!rst_n)
                aux_q[g] <= '0;
            else if (wr && (idx == IDX_W'(g + 2)))
                aux_q[g] <= bus_wdata;
        end
    end

    // Assemble the visible status word
    always_comb begin
        csr_word             = VERSION_WORD | (ctrl_q & STORE_MASK);
        csr_word[BIT_LOADED] = loaded;
        csr_word[BIT_PEND]   = pending;
    end

    // Zero-wait read mux
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (idx)
                IDX_CSR:  bus_rdata = csr_word;
                IDX_ADDR: bus_rdata = addr_word;
                IDX_AUX0: bus_rdata = aux_q[0];
                default:  bus_rdata = aux_q[NUM_AUX-1];
            endcase
        end
    end

    assign periph_reset_out = rst_pulse_q;
    assign dma_en_out       = ctrl_q[BIT_DMAEN];
endmodule

// File: rtl/dma_csr_checker.sv
// Module: property checker for dma_csr_block, attached by bind.
// Observes ports plus the assembled status and address words.
module dma_csr_checker
    import dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_csr,
    input logic             wr_addr,
    input logic             wd_reset,
    input logic             wd_dmaen,
    input logic             xfer_valid,
    input logic [LEN_W-1:0] xfer_len,
    input logic             irq_out,
    input logic             periph_reset_out,
    input logic             dma_en_out,
    input logic [REG_W-1:0] csr_word,
    input logic [REG_W-1:0] addr_word
);
    logic unused_csr;
    assign unused_csr = ^csr_word;

    // R3: hardwired status fields
    a_r3_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        csr_word[31:27] == 5'b10100 && !csr_word[25] && csr_word[2:1] == 2'b00);

    // R4: output equals enable AND pending
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (csr_word[BIT_IEN] & csr_word[BIT_PEND]));

    // R6: reset pulse only after a write carrying the reset bit
    a_r6_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        periph_reset_out |-> $past(wr_csr && wd_reset));

    // R6 R7: command bits never read back
    a_r7_cmd_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_word[BIT_DRAIN] && !csr_word[BIT_RESET]);

    // R8: DMA enable edges come only from matching writes
    a_r8_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en_out) |-> $past(wr_csr && wd_dmaen));
    a_r8_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_en_out) |-> $past(wr_csr && !wd_dmaen));

    // R9: loaded flag sets on address write and is sticky
    a_r9_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> csr_word[BIT_LOADED]);
    a_r9_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        csr_word[BIT_LOADED] |=> csr_word[BIT_LOADED]);

    // R10: advance by the transfer length when not overwritten
    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !wr_addr) |=>
            addr_word == $past(addr_word) + REG_W'($past(xfer_len)));
endmodule

bind dma_csr_block dma_csr_checker #(.LEN_W(LEN_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_csr           (bus_valid && bus_write && bus_addr[3:2] == 2'd0),
    .wr_addr          (bus_valid && bus_write && bus_addr[3:2] == 2'd1),
    .wd_reset         (bus_wdata[7]),
    .wd_dmaen         (bus_wdata[9]),
    .xfer_valid       (xfer_valid),
    .xfer_len         (xfer_len),
    .irq_out          (irq_out),
    .periph_reset_out (periph_reset_out),
    .dma_en_out       (dma_en_out),
    .csr_word         (csr_word),
    .addr_word        (addr_word)
);

// File: tb/dma_csr_block_bench.sv
// Bench: directed corner cases followed by seeded random traffic,
// all compared against a behavioural model kept in bench variables.
module dma_csr_block_bench;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 16;
    localparam logic [31:0] STORE = ~32'hFE00_0007 & ~32'h0000_00C0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              periph_irq = 1'b0;
    logic              xfer_valid = 1'b0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic              irq_out, periph_reset_out, dma_en_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state
    logic [31:0] m_ctrl = '0, m_addr = '0, m_aux2 = '0, m_aux3 = '0;
    logic        m_pend = 1'b0, m_prev = 1'b0, m_loaded = 1'b0, m_rstp = 1'b0, m_irq = 1'b0;

    always #5 clk = ~clk;

    dma_csr_block #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dma_csr_block (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_irq(periph_irq), .xfer_valid(xfer_valid), .xfer_len(xfer_len),
        .irq_out(irq_out), .periph_reset_out(periph_reset_out), .dma_en_out(dma_en_out)
    );

    function automatic logic [31:0] model_read(input logic [1:0] i);
        logic [31:0] c;
        c = 32'hA000_0000 | (m_ctrl & STORE);
        c[26] = m_loaded;
        c[0]  = m_pend;
        case (i)
            2'd0:    return c;
            2'd1:    return m_addr;
            2'd2:    return m_aux2;
            default: return m_aux3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at the falling edge, check reads, step the model
    task automatic cyc(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                       input logic [31:0] wd, input bit irq, input bit xv,
                       input logic [LEN_W-1:0] len);
        logic [1:0] i;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = wd;
        periph_irq = irq; xfer_valid = xv; xfer_len = len;
        i = a[3:2];
        #1;
        if (v && !w)
            check(bus_rdata == model_read(i), i == 2'd0 ? "R1 R3 read status" : "R1 read word",
                  bus_rdata, model_read(i));
        else
            check(bus_rdata == 32'h0, "R13 idle rdata", bus_rdata, 32'h0);
        @(posedge clk);
        #1;
        // model step: write applied, then edge and advance rules
        m_rstp = 1'b0;
        if (v && w && i == 2'd0) begin
            m_ctrl = wd & STORE;
            m_rstp = wd[7];
        end
        if (v && w && i == 2'd2) m_aux2 = wd;
        if (v && w && i == 2'd3) m_aux3 = wd;
        if (v && w && i == 2'd1) begin
            m_addr   = wd;
            m_loaded = 1'b1;
        end else if (xv) begin
            m_addr = m_addr + 32'(len);
        end
        if (irq && !m_prev) m_pend = 1'b1;
        else if (!irq && m_prev) m_pend = 1'b0;
        m_prev = irq;
        m_irq  = m_ctrl[4] & m_pend;
        check(irq_out == m_irq, "R4 R5 R12 irq_out", 32'(irq_out), 32'(m_irq));
        check(periph_reset_out == m_rstp, "R6 reset pulse", 32'(periph_reset_out), 32'(m_rstp));
        check(dma_en_out == m_ctrl[9], "R8 dma enable", 32'(dma_en_out), 32'(m_ctrl[9]));
    endtask

    task automatic rd_check(input logic [ADDR_W-1:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        xfer_valid = 1'b0;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2: reset values
        check(irq_out == 1'b0 && periph_reset_out == 1'b0 && dma_en_out == 1'b0,
              "R2 outputs after reset", {29'b0, irq_out, periph_reset_out, dma_en_out}, 32'h0);
        rd_check(8'h00, "R2 status reset", 32'hA000_0000);
        rd_check(8'h04, "R2 address reset", 32'h0);
        rd_check(8'h08, "R2 scratch reset", 32'h0);
        rd_check(8'h0C, "R2 scratch reset", 32'h0);

        // R3 R6 R7 R8: all-ones write to status
        cyc(1, 1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
        check(periph_reset_out == 1'b1, "R6 pulse high", 32'(periph_reset_out), 32'h1);
        check(dma_en_out == 1'b1, "R8 enable rise", 32'(dma_en_out), 32'h1);
        rd_check(8'h00, "R3 R7 status after ones", 32'hA000_0000 | STORE);
        check(periph_reset_out == 1'b0, "R6 pulse one cycle", 32'(periph_reset_out), 32'h0);
        cyc(1, 1, 8'h00, 32'h0, 0, 0, 0);
        check(dma_en_out == 1'b0, "R8 enable fall", 32'(dma_en_out), 32'h0);

        // R4 R5: pending while disabled, then enable, then input falls
        cyc(0, 0, 0, 0, 1, 0, 0);
        rd_check(8'h00, "R4 pending set", 32'hA000_0001);
        check(irq_out == 1'b0, "R4 gated off", 32'(irq_out), 32'h0);
        periph_irq = 1'b1;
        cyc(1, 1, 8'h00, 32'h10, 1, 0, 0);
        check(irq_out == 1'b1, "R5 enable with pending", 32'(irq_out), 32'h1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        check(irq_out == 1'b0, "R4 falling input", 32'(irq_out), 32'h0);

        // R12: enable write and rising edge in one cycle
        cyc(1, 1, 8'h00, 32'h0, 0, 0, 0);
        cyc(1, 1, 8'h00, 32'h10, 1, 0, 0);
        check(irq_out == 1'b1, "R12 write with rise", 32'(irq_out), 32'h1);
        cyc(1, 1, 8'h00, 32'h0, 1, 0, 0);
        check(irq_out == 1'b0, "R5 disable drops", 32'(irq_out), 32'h0);

        // R9 R11 R1: aliased address write colliding with a transfer
        cyc(1, 1, 8'hF5, 32'h1000_0000, 1, 1, 16'h0040);
        rd_check(8'h04, "R11 write wins", 32'h1000_0000);
        rd_check(8'h00, "R9 loaded flag", 32'hA400_0001);
        cyc(0, 0, 0, 0, 1, 1, 16'hFFFF);
        rd_check(8'h34, "R10 advance", 32'h1000_FFFF);

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], r[2], ADDR_W'($urandom), (r[3] ? $urandom : {$urandom} & 32'h0000_02D0),
                (r[5:4] == 2'b00) ? ~periph_irq : periph_irq, r[6] & r[7], LEN_W'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule